// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives up to eight chip-select lines for a serial-peripheral master. Each line has two configuration bits. An enable bit routes the line's internal state to its pin. A polarity bit inverts the pin, so a device that selects on a high level can share the bus with devices that select on a low level.

Software changes lines through a force register. The force register has one set field and one clear field. One write can raise some lines, lower others and leave the rest alone, so no read-modify-write is needed. A status address reads back the internal states.

The internal state of a line is 1 when the line is released and 0 when it is selected. After reset, or after writing 0x0000 to control and then 0xFF00 to force, every pin sits at its released level.

Top module: `cs_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0000. The status register reads 0x00FF, and every pin of `cs_out` is 1.
- R2: A write to address 0 (control) stores the enable of line n in bit 8+n and the polarity of line n in bit n. Reading address 0 returns these bits, with all other bits 0.
- R3: A write to address 1 (force) with bit 8+n set and bit n clear makes the internal state of line n equal to 1 (released).
- R4: A write to address 1 with bit n set and bit 8+n clear makes the internal state of line n equal to 0 (selected).
- R5: In a force write, a line with both bits set keeps its internal state. A line with neither bit set also keeps its internal state.
- R6: For an enabled line, the pin equals the internal state XOR the polarity bit. The pin updates in the cycle after the write. Without a write, the pins do not change.
- R7: For a disabled line, the pin rests at its released level, which is the inverse of the polarity bit, whatever the internal state.
- R8: Reading address 2 (status) returns the internal state of line n in bit n, with bits 8 to 15 equal to 0.
- R9: Writes to address 2 or 3 change nothing. A write to address 1 leaves the control register unchanged. Reading address 1 or address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 force, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cs_out | output | 8 | Chip-select pins |

## Verification
The assertions check the force-register semantics on every cycle:
- set-only bits release a line;
- clear-only bits select it;
- conflicting bits hold its state.

They also check that the pins move only after a write, and that the control settings survive writes to other addresses.

The polarity mapping of the pins and the resting level of disabled lines are combinational views of the stored state. Only the bench shows these, by comparing the pins and the read-back values against its own model after directed and random writes. That includes the active-high case and the lines that are disabled but inverted.

// File: rtl/cs_ctrl.sv
module cs_ctrl #(
  parameter int LINES     = 8,
  parameter int FIELD_OFS = 8,
  parameter int AW        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [2*FIELD_OFS-1:0] reg_wdata,
  output logic [2*FIELD_OFS-1:0] reg_rdata,
  output logic [LINES-1:0]       cs_out
);
  localparam int DW = 2*FIELD_OFS;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_FORCE = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);

  logic [LINES-1:0] en_q, inv_q, st_q;

  wire [LINES-1:0] hi_f = reg_wdata[FIELD_OFS +: LINES];
  wire [LINES-1:0] lo_f = reg_wdata[0 +: LINES];
  wire [LINES-1:0] rise = hi_f & ~lo_f;
  wire [LINES-1:0] fall = lo_f & ~hi_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      inv_q <= '0;
      st_q  <= '1;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        en_q  <= hi_f;
        inv_q <= lo_f;
      end
      if (reg_addr == A_FORCE)
        st_q <= (st_q | rise) & ~fall;
    end
  end

  assign cs_out = (st_q | ~en_q) ^ inv_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[FIELD_OFS +: LINES] = en_q;
      reg_rdata[0 +: LINES]         = inv_q;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[0 +: LINES] = st_q;
    end
  end
endmodule

// File: rtl/cs_ctrl_chk.sv
module cs_ctrl_chk #(
  parameter int LINES     = 8,
  parameter int FIELD_OFS = 8,
  parameter int AW        = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [AW-1:0]          reg_addr,
  input logic [2*FIELD_OFS-1:0] reg_wdata,
  input logic [LINES-1:0]       cs_out,
  input logic [LINES-1:0]       st_q,
  input logic [LINES-1:0]       en_q,
  input logic [LINES-1:0]       inv_q
);
  wire [LINES-1:0] hi_f = reg_wdata[FIELD_OFS +: LINES];
  wire [LINES-1:0] lo_f = reg_wdata[0 +: LINES];
  wire force_wr = reg_wr && (reg_addr == AW'(1));

  AST_SET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> ((st_q & $past(hi_f & ~lo_f)) == $past(hi_f & ~lo_f))); // R3
  AST_CLR_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> ((st_q & $past(lo_f & ~hi_f)) == '0)); // R4
  AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (((st_q ^ $past(st_q)) & $past(hi_f & lo_f)) == '0)); // R5
  AST_IDLE_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(cs_out)); // R6
  AST_CTRL_ONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != AW'(0)) |=> $stable({en_q, inv_q})); // R9
endmodule

bind cs_ctrl cs_ctrl_chk #(.LINES(LINES), .FIELD_OFS(FIELD_OFS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cs_out(cs_out), .st_q(st_q), .en_q(en_q), .inv_q(inv_q)
);

// File: tb/cs_ctrl_test.sv
`timescale 1ns/1ps
module cs_ctrl_test;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [7:0] cs_out;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_en = '0, m_inv = '0, m_st = '1;

  always #4 clk = ~clk;

  cs_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_out(cs_out));

  function automatic logic [7:0] exp_pins(logic [7:0] en, logic [7:0] inv, logic [7:0] st);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = en[i] ? (st[i] ^ inv[i]) : ~inv[i];
    return p;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a == 2'd0) begin m_en = d[15:8]; m_inv = d[7:0]; end
    if (a == 2'd1) m_st = (m_st | (d[15:8] & ~d[7:0])) & ~(d[7:0] & ~d[15:8]);
  endtask

  task automatic check_all(string tag);
    logic [15:0] d;
    check({tag, " R6/R7 pins"}, {8'h0, cs_out}, {8'h0, exp_pins(m_en, m_inv, m_st)});
    rd(2'd2, d); check({tag, " R8 status"}, d, {8'h0, m_st});
    rd(2'd0, d); check({tag, " R2 ctrl"}, d, {m_en, m_inv});
  endtask

  initial begin
    #(8*150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int unsigned seed;
    seed = $urandom(32'hC5A1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", {8'h0, cs_out}, 16'h00FF);
    rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
    rd(2'd2, d); check("R1 status", d, 16'h00FF);
    rst_n = 1;
    // R3 deassert-all sequence
    wr(2'd0, 16'h0000); wr(2'd1, 16'hFF00);
    check("R3 released", {8'h0, cs_out}, 16'h00FF);
    // R4/R6 active-high line 2 selected
    wr(2'd0, 16'h0404); wr(2'd1, 16'h0004);
    rd(2'd2, d); check("R4 status", d, 16'h00FB);
    check("R6 active-high pin", {8'h0, cs_out}, 16'h00FF);
    wr(2'd1, 16'h0400);
    check("R6 released high-active", {8'h0, cs_out}, 16'h00FB);
    // R5 conflicting and empty writes hold
    wr(2'd1, 16'h0004);
    wr(2'd1, 16'h0404);
    rd(2'd2, d); check("R5 both bits hold", d, 16'h00FB);
    wr(2'd1, 16'h0000);
    rd(2'd2, d); check("R5 no bits hold", d, 16'h00FB);
    // R7 disabled inverted lines rest low
    wr(2'd0, 16'h0003);
    check("R7 disabled rest", {8'h0, cs_out}, 16'h00FC);
    // R9 ignored writes
    wr(2'd2, 16'h0000); wr(2'd3, 16'hFFFF);
    rd(2'd2, d); check("R9 status write ignored", d, 16'h00FB);
    rd(2'd0, d); check("R9 ctrl untouched", d, 16'h0003);
    rd(2'd1, d); check("R9 force reads 0", d, 16'h0000);
    rd(2'd3, d); check("R9 addr3 reads 0", d, 16'h0000);
    check("R9 pins", {8'h0, cs_out}, 16'h00FC);
    // random mix
    for (int k = 0; k < 400; k++) begin
      wr(2'($urandom % 4), 16'($urandom));
      check_all("rand");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule